// File: doc/BRIEF.md
# Multi-channel conversion sequencer

This block schedules the conversions of a multi-channel converter. It receives a configuration word (operating mode, status-append flag, filter rate, filter order, chop enable) and a channel-enable mask. It then visits the enabled channels in ascending index order. In single mode it makes one pass and then drops into power-down. In continuous mode it wraps around indefinitely. Continuous mode is what runs after reset. The modulator and filter are not modelled: each result takes its value from the `conv_sample` stub input at the moment the conversion completes.

Conversion timing comes from the filter settings. The length of one filter period is `CLK_DIV * FS` clock cycles, multiplied by the filter order when chop is on. A conversion that follows a channel change, a start-up or a new configuration needs several periods to settle. A repeated conversion on the same single channel needs only one period. Every start passes through an oscillator wake-up delay first.

Results leave through a valid/ready stream. The result stays stable while it waits for `res_ready`. If a new result completes while the old one is still unread, the old result is overwritten and `res_overrun` pulses. `res_valid` is then withdrawn for an update window, during which no read is possible. This is the one case where valid falls without a handshake, and a consumer must tolerate it.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the block runs in continuous mode on the reset mask (channel 0 only) with the reset filter rate of 2, third-order filter and chop off, so that after the first result further results follow every 8 cycles.
- R2: Mode value 3'b001 selects single mode: each enabled channel is converted once in ascending order, after which `powered_down` is 1 and no further `conv_done` occurs.
- R3: Mode value 3'b000 selects continuous mode: conversions cycle through the enabled channels in ascending order and wrap from the highest enabled channel to the lowest.
- R4: A configuration with an all-zero channel mask puts the block in power-down (`powered_down`=1) with no conversions.
- R5: One filter period lasts `CLK_DIV*FS` cycles with chop off, and `CLK_DIV*FS*3` (third order) or `CLK_DIV*FS*4` (fourth order) with chop on. An FS value of 0 counts as 1.
- R6: A conversion that follows a start or a channel change takes a settling count of periods: 3 (third order) or 4 (fourth order) with chop off, and 2 with chop on. A repeated conversion on the same channel takes 1 period.
- R7: After `cfg_load` with a valid mode and a non-empty mask, the first `conv_done` comes `WAKE_CYC + settle*period` cycles later, and `powered_down` is 0 throughout that interval.
- R8: `res_word` carries the sample in its upper `DATA_W` bits. The low 8-bit status byte holds the channel index when the append flag is set, and is zero when it is not.
- R9: While `res_valid`=1 and `res_ready`=0, `res_word` stays stable until a new result completes. A handshake (valid and ready high at a clock edge) clears `res_valid`.
- R10: A result that completes while the previous one is unread pulses `res_overrun` together with `conv_done`, holds `res_valid` low for `UPD_CYC` cycles, and then presents the new result.
- R11: A result that completes when no unread result is held makes `res_valid` high in the same cycle as `conv_done`, with no overrun.
- R12: A mode value other than 3'b000 or 3'b001 puts the block in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | One-cycle strobe that loads the configuration and restarts the sequence |
| cfg_mode | input | 3 | Operating mode: 000 continuous, 001 single, others power-down |
| cfg_append | input | 1 | Place the channel index in the status byte |
| cfg_fs | input | FS_W | Filter rate divider |
| cfg_sinc4 | input | 1 | 1 selects a fourth-order filter, 0 a third-order filter |
| cfg_chop | input | 1 | Chop enable |
| cfg_mask | input | NUM_CH | Channel-enable mask |
| conv_sample | input | DATA_W | Stub conversion value, captured when a conversion completes |
| conv_done | output | 1 | One-cycle conversion-complete strobe |
| done_chan | output | CH_W | Channel of the conversion that just completed |
| powered_down | output | 1 | Sequencer idle in power-down |
| res_valid | output | 1 | Result available to read |
| res_ready | input | 1 | Consumer accepts the result |
| res_word | output | DATA_W+8 | Sample followed by the status byte |
| res_overrun | output | 1 | Unread result was overwritten |

## Verification
The checker assumes that `cfg_load` is never asserted in the same cycle as a completing conversion. The block suppresses that completion, so channel-mask checks always refer to the mask that was in force when the result was produced. It also assumes that `res_ready` is driven only from register outputs, so the handshake is sampled cleanly at the edge. The stimulus changes all inputs just after a clock edge and keeps `conv_sample` constant around each expected completion. In the overrun scenario it uses a filter period much longer than `UPD_CYC`, so that one update window always ends before the next result arrives.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAKE = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;

  localparam logic [2:0] MODE_CONT   = 3'b000;
  localparam logic [2:0] MODE_SINGLE = 3'b001;
  localparam int         STAT_W      = 8;
endpackage

// File: rtl/conv_period_timer.sv
module conv_period_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PER_W-1:0] per_len,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == per_len - PER_W'(1));
  assign tick   = at_end && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || at_end) cnt_q <= '0;
    else                       cnt_q <= cnt_q + PER_W'(1);
  end
endmodule

// File: rtl/conv_chan_pick.sv
module conv_chan_pick #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W-1:0]   cur,
  output logic [CH_W-1:0]   next_hi,
  output logic              has_hi,
  output logic [CH_W-1:0]   lowest
);
  always_comb begin
    next_hi = '0;
    has_hi  = 1'b0;
    lowest  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i]) lowest = CH_W'(i);
      if (mask[i] && (CH_W'(i) > cur)) begin
        next_hi = CH_W'(i);
        has_hi  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_result_buf.sv
module conv_result_buf #(
  parameter int WORD_W  = 32,
  parameter int UPD_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic              res_overrun
);
  localparam int UPD_W = $clog2(UPD_CYC + 1);

  logic             full_q;
  logic [UPD_W-1:0] upd_q;
  logic             take;

  assign res_valid = full_q && (upd_q == '0);
  assign take      = res_valid && res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q      <= 1'b0;
      upd_q       <= '0;
      res_word    <= '0;
      res_overrun <= 1'b0;
    end else begin
      res_overrun <= 1'b0;
      if (upd_q != '0) upd_q <= upd_q - UPD_W'(1);
      if (load) begin
        res_word <= load_word;
        full_q   <= 1'b1;
        if (full_q && !take) begin
          upd_q       <= UPD_W'(UPD_CYC);
          res_overrun <= 1'b1;
        end
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int DATA_W   = 24,
  parameter int FS_W     = 10,
  parameter int CLK_DIV  = 4,
  parameter int WAKE_CYC = 20,
  parameter int UPD_CYC  = 6,
  parameter int RST_FS   = 2,
  parameter logic [NUM_CH-1:0] RST_MASK = NUM_CH'(1),
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WORD_W  = DATA_W + STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [2:0]        cfg_mode,
  input  logic              cfg_append,
  input  logic [FS_W-1:0]   cfg_fs,
  input  logic              cfg_sinc4,
  input  logic              cfg_chop,
  input  logic [NUM_CH-1:0] cfg_mask,
  input  logic [DATA_W-1:0] conv_sample,
  output logic              conv_done,
  output logic [CH_W-1:0]   done_chan,
  output logic              powered_down,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_word,
  output logic              res_overrun
);
  localparam int PER_W  = FS_W + $clog2(CLK_DIV + 1) + 4;
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);

  seq_state_e        state_q;
  logic              single_q, append_q, sinc4_q, chop_q;
  logic [FS_W-1:0]   fs_q;
  logic [NUM_CH-1:0] cfg_mask_q;
  logic [CH_W-1:0]   cur_q;
  logic [2:0]        need_q, pc_q;
  logic [WAKE_W-1:0] wake_q;

  logic [FS_W-1:0]   fs_eff;
  logic [2:0]        mul, settle;
  logic [PER_W-1:0]  per_len;
  logic              tick, done, start_ok;
  logic [CH_W-1:0]   next_hi, lowest, next_ch;
  logic              has_hi;

  assign fs_eff  = (fs_q == '0) ? FS_W'(1) : fs_q;
  assign mul     = chop_q ? (sinc4_q ? 3'd4 : 3'd3) : 3'd1;
  assign settle  = chop_q ? 3'd2 : (sinc4_q ? 3'd4 : 3'd3);
  assign per_len = PER_W'(CLK_DIV) * PER_W'(fs_eff) * PER_W'(mul);
  assign done    = (state_q == ST_CONV) && tick && (pc_q == need_q - 3'd1);
  assign next_ch = has_hi ? next_hi : lowest;
  assign start_ok = ((cfg_mode == MODE_CONT) || (cfg_mode == MODE_SINGLE)) && (cfg_mask != '0);
  assign powered_down = (state_q == ST_OFF);

  conv_period_timer #(.PER_W(PER_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_q != ST_CONV),
    .per_len (per_len),
    .tick    (tick)
  );

  conv_chan_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .mask    (cfg_mask_q),
    .cur     (cur_q),
    .next_hi (next_hi),
    .has_hi  (has_hi),
    .lowest  (lowest)
  );

  conv_result_buf #(.WORD_W(WORD_W), .UPD_CYC(UPD_CYC)) u_rbuf (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (done && !cfg_load),
    .load_word   ({conv_sample, append_q ? STAT_W'(cur_q) : STAT_W'(0)}),
    .res_ready   (res_ready),
    .res_valid   (res_valid),
    .res_word    (res_word),
    .res_overrun (res_overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_WAKE;
      single_q   <= 1'b0;
      append_q   <= 1'b0;
      sinc4_q    <= 1'b0;
      chop_q     <= 1'b0;
      fs_q       <= FS_W'(RST_FS);
      cfg_mask_q <= RST_MASK;
      cur_q      <= '0;
      need_q     <= 3'd1;
      pc_q       <= '0;
      wake_q     <= '0;
      conv_done  <= 1'b0;
      done_chan  <= '0;
    end else begin
      conv_done <= done && !cfg_load;
      if (done) done_chan <= cur_q;
      if (cfg_load) begin
        single_q   <= (cfg_mode == MODE_SINGLE);
        append_q   <= cfg_append;
        sinc4_q    <= cfg_sinc4;
        chop_q     <= cfg_chop;
        fs_q       <= cfg_fs;
        cfg_mask_q <= cfg_mask;
        wake_q     <= '0;
        state_q    <= start_ok ? ST_WAKE : ST_OFF;
      end else begin
        unique case (state_q)
          ST_WAKE: begin
            if (wake_q == WAKE_W'(WAKE_CYC - 1)) begin
              state_q <= ST_CONV;
              cur_q   <= lowest;
              need_q  <= settle;
              pc_q    <= '0;
            end else begin
              wake_q <= wake_q + WAKE_W'(1);
            end
          end
          ST_CONV: begin
            if (tick) pc_q <= done ? 3'd0 : pc_q + 3'd1;
            if (done) begin
              if (single_q && !has_hi) begin
                state_q <= ST_OFF;
              end else begin
                cur_q  <= next_ch;
                need_q <= (next_ch == cur_q) ? 3'd1 : settle;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [CH_W-1:0]   done_chan,
  input logic [NUM_CH-1:0] mask_q,
  input logic              powered_down,
  input logic              res_valid,
  input logic              res_ready,
  input logic [WORD_W-1:0] res_word,
  input logic              res_overrun
);
  AST_CHAN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> mask_q[done_chan]); // R3
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    powered_down |=> !conv_done); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_overrun || conv_done || (res_valid && $stable(res_word)))); // R9
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_valid || conv_done)); // R9
  AST_OVR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    res_overrun |-> (conv_done && !res_valid)); // R10
  AST_FRESH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !res_overrun) |-> res_valid); // R11
endmodule

bind conv_sequencer conv_sequencer_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .WORD_W(WORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_done    (conv_done),
  .done_chan    (done_chan),
  .mask_q       (cfg_mask_q),
  .powered_down (powered_down),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_word     (res_word),
  .res_overrun  (res_overrun)
);

// File: tb/conv_sequencer_tb.sv
module conv_sequencer_tb;
  localparam int NUM_CH = 4, DATA_W = 24, FS_W = 10, CH_W = 2, WORD_W = 32;
  localparam int CLK_DIV = 4, WAKE_CYC = 20, UPD_CYC = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, cfg_append = 0, cfg_sinc4 = 0, cfg_chop = 0, res_ready = 0;
  logic [2:0] cfg_mode = 0;
  logic [FS_W-1:0] cfg_fs = 0;
  logic [NUM_CH-1:0] cfg_mask = 0;
  logic [DATA_W-1:0] conv_sample = 0;
  logic conv_done, powered_down, res_valid, res_overrun;
  logic [CH_W-1:0] done_chan;
  logic [WORD_W-1:0] res_word;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  conv_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_append(cfg_append), .cfg_fs(cfg_fs), .cfg_sinc4(cfg_sinc4),
    .cfg_chop(cfg_chop), .cfg_mask(cfg_mask), .conv_sample(conv_sample),
    .conv_done(conv_done), .done_chan(done_chan), .powered_down(powered_down),
    .res_valid(res_valid), .res_ready(res_ready), .res_word(res_word),
    .res_overrun(res_overrun)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin step(); n++; end while (!conv_done && n < 5000);
  endtask

  task automatic do_reset();
    rst_n = 0; cfg_load = 0; res_ready = 0;
    repeat (3) step();
    rst_n = 1;
  endtask

  task automatic load(input logic [2:0] m, input logic [NUM_CH-1:0] msk,
                      input int fs, input bit s4, input bit ch, input bit app);
    cfg_mode = m; cfg_mask = msk; cfg_fs = FS_W'(fs);
    cfg_sinc4 = s4; cfg_chop = ch; cfg_append = app; cfg_load = 1;
    step();
    cfg_load = 0;
  endtask

  task automatic t_reset();
    int n;
    do_reset();
    chk(!powered_down, "R1 awake after reset", powered_down, 0);
    chk(!res_valid, "R1 no result after reset", res_valid, 0);
    res_ready = 1;
    wait_done(n);
    chk(done_chan == 0, "R1 reset channel", done_chan, 0);
    wait_done(n);
    chk(n == 8, "R1 reset interval", n, 8);
  endtask

  task automatic t_continuous();
    int n;
    res_ready = 1; conv_sample = 24'h00A5C3;
    load(3'b000, 4'b0101, 1, 0, 0, 1);
    wait_done(n);
    for (int k = 0; k < 4; k++) begin
      wait_done(n);
      chk(n == 12, "R6 interval after channel change", n, 12);
      chk(done_chan == ((k % 2 == 0) ? 2 : 0), "R3 ascending wrap order", done_chan, (k % 2 == 0) ? 2 : 0);
      chk(res_valid && res_word == {24'h00A5C3, 8'(done_chan)}, "R8 word with status", res_word, {24'h00A5C3, 8'(done_chan)});
    end
  endtask

  task automatic t_filters();
    int n;
    res_ready = 1;
    load(3'b000, 4'b0011, 2, 1, 0, 0);
    wait_done(n); wait_done(n);
    chk(n == 32, "R5 fourth order chop off", n, 32);
    load(3'b000, 4'b0011, 1, 0, 1, 0);
    wait_done(n); wait_done(n);
    chk(n == 24, "R6 chop third order", n, 24);
    load(3'b000, 4'b0011, 0, 1, 1, 0);
    wait_done(n); wait_done(n);
    chk(n == 32, "R5 chop fourth order FS zero", n, 32);
    load(3'b000, 4'b0001, 1, 0, 0, 0);
    wait_done(n);
    chk(n == WAKE_CYC + 12, "R7 wake plus settle", n, WAKE_CYC + 12);
    wait_done(n);
    chk(n == 4, "R6 same channel one period", n, 4);
  endtask

  task automatic t_single();
    int n, dones;
    res_ready = 1; conv_sample = 24'h123456;
    load(3'b001, 4'b1011, 1, 0, 0, 0);
    chk(!powered_down, "R7 awake during wake", powered_down, 0);
    wait_done(n); chk(done_chan == 0, "R2 first channel", done_chan, 0);
    chk(res_word == {24'h123456, 8'h00}, "R8 no status byte", res_word, {24'h123456, 8'h00});
    wait_done(n); chk(done_chan == 1, "R2 second channel", done_chan, 1);
    wait_done(n); chk(done_chan == 3, "R2 third channel", done_chan, 3);
    chk(powered_down, "R2 power-down after pass", powered_down, 1);
    dones = 0;
    for (int k = 0; k < 100; k++) begin step(); dones += conv_done; end
    chk(dones == 0, "R2 no conversions after pass", dones, 0);
  endtask

  task automatic t_off();
    int dones = 0;
    load(3'b000, 4'b0000, 1, 0, 0, 0);
    chk(powered_down, "R4 empty mask power-down", powered_down, 1);
    for (int k = 0; k < 100; k++) begin step(); dones += conv_done; end
    chk(dones == 0, "R4 empty mask no conversions", dones, 0);
    load(3'b010, 4'b0001, 1, 0, 0, 0);
    chk(powered_down, "R12 bad mode power-down", powered_down, 1);
  endtask

  task automatic t_overrun();
    int n, low;
    do_reset();
    res_ready = 0; conv_sample = 24'h000111;
    load(3'b000, 4'b0001, 4, 0, 0, 0);
    wait_done(n);
    chk(res_valid && !res_overrun, "R11 fresh result valid", res_valid, 1);
    conv_sample = 24'h000222;
    for (int k = 0; k < 5; k++) begin
      step();
      chk(res_valid && res_word[31:8] == 24'h000111, "R9 held while not ready", res_word[31:8], 24'h000111);
    end
    wait_done(n);
    chk(res_overrun && !res_valid, "R10 overrun flagged", res_overrun, 1);
    low = 0;
    while (!res_valid && low < 50) begin low++; step(); end
    chk(low == UPD_CYC, "R10 update window length", low, UPD_CYC);
    chk(res_word[31:8] == 24'h000222, "R10 new result shown", res_word[31:8], 24'h000222);
    res_ready = 1; step(); res_ready = 0;
    chk(!res_valid, "R9 handshake clears", res_valid, 0);
    wait_done(n);
    chk(res_valid && !res_overrun, "R11 no overrun after read", res_overrun, 0);
  endtask

  initial begin
    t_reset();
    t_continuous();
    t_filters();
    t_single();
    t_off();
    t_overrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end
endmodule